// File: doc/BRIEF.md
# Framed Serial Port Transmitter

This block is the transmit half of a synchronous framed serial port. A host writes a word as two 16-bit halves into a pair of holding registers. Writing the low half hands the whole word to a one-word transmit buffer. On that handoff the low half can be compressed to an 8-bit μ-law or A-law code. The buffered word stays where it is until a frame-sync pulse arrives. After the pulse and a programmable delay of zero to two bit slots, the word is shifted out MSB first, one bit for each bit-clock enable.

A ready flag tells the host when the holding registers may be written again. If a frame sync finds no new word in the buffer, the previous word is sent again and a sticky underflow flag is raised. All logic runs on one system clock. The serial bit rate is set by the `bit_en_i` strobe, and frame sync is sampled only on cycles where that strobe is high.

Top module: `fsp_tx`

## Requirements
- R1: After reset, `xrdy_o` is 1 and `dx_oe_o`, `dx_o` and `uf_o` are 0.
- R2: A write of the low half (`wr_lo_i`) drives `xrdy_o` to 0 on the next clock edge. If the transmit buffer is empty, the word is copied on the following edge and `xrdy_o` returns to 1.
- R3: While the buffer still holds an unsent word, a newly written word waits and `xrdy_o` stays 0. The waiting word is copied, and `xrdy_o` set, one clock after a frame start takes the buffered word.
- R4: The word length is `wlen_i`+1 bits, with `wlen_i` values below 7 treated as 7. The bits sent are bits [len-1:0] of {high half, low half}, MSB first, one per `bit_en_i` slot, and the outputs change only on clocks where `bit_en_i` is high.
- R5: If the high half is not rewritten, its previous value forms the upper bits of the next long word.
- R6: When `cmp_mode_i` is 2'b10, the low half is treated as a signed 16-bit sample and sent as an 8-bit μ-law code. The code is built from a bias of 132, a clip at 32635 and a segment/mantissa split, then bit-inverted. `wlen_i` and the high half are ignored.
- R7: When `cmp_mode_i` is 2'b11, the sample is sent as an 8-bit A-law code. The code is taken from the 13-bit arithmetic-shifted sample, with segment/mantissa bits XORed by 8'hD5 for non-negative samples and 8'h55 for negative ones.
- R8: When `cmp_mode_i` is 2'b00 or 2'b01, the data is sent unmodified.
- R9: `delay_i` of 0, 1 or 2 places the MSB in the slot of the frame sync or 1 or 2 slots later, and 2'b11 acts as 2. `dx_oe_o` is high for exactly len slots and low in the delay slots and in the slot after the LSB.
- R10: A frame sync during the delay or before the LSB slot has ended is ignored. One in the slot right after the LSB starts the next word without a gap.
- R11: A frame start with no new word in the buffer resends the previous word and sets `uf_o`. `uf_o` stays set until `uf_clr_i` is pulsed.
- R12: Whenever `dx_oe_o` is 0, `dx_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_lo_i | input | 1 | Write strobe for the low half; starts the handoff |
| wr_hi_i | input | 1 | Write strobe for the high half |
| wdata_i | input | 16 | Host write data |
| wlen_i | input | 5 | Word length minus one |
| cmp_mode_i | input | 2 | 00/01 none, 10 μ-law, 11 A-law |
| delay_i | input | 2 | Bit slots from frame sync to MSB (3 acts as 2) |
| bit_en_i | input | 1 | Serial bit-clock enable, one pulse per bit slot |
| fs_i | input | 1 | Frame sync, sampled when bit_en_i is high |
| uf_clr_i | input | 1 | Clears the underflow flag |
| xrdy_o | output | 1 | Holding registers may be written |
| dx_o | output | 1 | Serial data |
| dx_oe_o | output | 1 | Serial data valid / drive enable |
| uf_o | output | 1 | Sticky underflow flag |

## Verification
Some rules are checked on every cycle: ready falls after a low-half write, the serial outputs hold still between bit enables, the data line stays quiet when not enabled, and the underflow flag stays set until it is cleared. The rest can only be shown by the bench's scenarios. These are the bit order and length of each word, the companded codes, the delay placement, reuse of a stale high half, ready being held back while the buffer is full, ignored and back-to-back frame syncs, and the resend on underflow.

// File: rtl/fsp_tx_pkg.sv
package fsp_tx_pkg;

  typedef enum logic [1:0] {
    CMP_NONE0 = 2'b00,
    CMP_NONE1 = 2'b01,
    CMP_MU    = 2'b10,
    CMP_A     = 2'b11
  } cmp_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_DELAY = 2'd1,
    ST_SHIFT = 2'd2
  } tx_state_e;

  // 16-bit signed linear to 8-bit mu-law
  function automatic logic [7:0] mu_encode(logic [15:0] s);
    logic        sgn;
    logic [16:0] mag;
    logic [2:0]  seg;
    logic [3:0]  mant;
    sgn = s[15];
    mag = sgn ? (17'h10000 - {1'b0, s}) : {1'b0, s};
    if (mag > 17'd32635) mag = 17'd32635;
    mag = mag + 17'd132;
    seg = 3'd0;
    for (int i = 1; i < 8; i++) begin
      if (mag[i+7]) seg = 3'(i);
    end
    mant = 4'(mag >> (32'(seg) + 32'd3));
    return ~{sgn, seg, mant};
  endfunction

  // 16-bit signed linear to 8-bit A-law
  function automatic logic [7:0] a_encode(logic [15:0] s);
    logic        pos;
    logic [11:0] m;
    logic [2:0]  seg;
    logic [3:0]  mant;
    pos = ~s[15];
    m   = pos ? s[14:3] : ~s[14:3];
    seg = 3'd0;
    for (int i = 1; i < 8; i++) begin
      if (m[i+4]) seg = 3'(i);
    end
    mant = (seg < 3'd2) ? m[4:1] : 4'(m >> seg);
    return {1'b0, seg, mant} ^ (pos ? 8'hD5 : 8'h55);
  endfunction

endpackage

// File: rtl/fsp_tx_compand.sv
module fsp_tx_compand #(
  parameter  int DW = 32,
  localparam int HW = DW / 2,
  localparam int IW = $clog2(DW)
) (
  input  logic [1:0]    cmp_mode_i,
  input  logic [IW-1:0] wlen_i,
  input  logic [HW-1:0] hi_i,
  input  logic [HW-1:0] lo_i,
  output logic [DW-1:0] word_o,
  output logic [IW-1:0] top_o
);
  import fsp_tx_pkg::*;

  localparam logic [IW-1:0] MIN_TOP = IW'(7);

  logic [7:0] code;

  always_comb begin
    code = (cmp_mode_e'(cmp_mode_i) == CMP_A) ? a_encode(lo_i[15:0]) : mu_encode(lo_i[15:0]);
    if (cmp_mode_i[1]) begin
      word_o = {{(DW-8){1'b0}}, code};
      top_o  = MIN_TOP;
    end else begin
      word_o = {hi_i, lo_i};
      top_o  = (wlen_i < MIN_TOP) ? MIN_TOP : wlen_i;
    end
  end

endmodule

// File: rtl/fsp_tx_hold.sv
module fsp_tx_hold #(
  parameter  int DW = 32,
  localparam int HW = DW / 2,
  localparam int IW = $clog2(DW)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_lo_i,
  input  logic          wr_hi_i,
  input  logic [HW-1:0] wdata_i,
  input  logic [DW-1:0] conv_word_i,
  input  logic [IW-1:0] conv_top_i,
  input  logic          take_i,
  output logic [HW-1:0] dxr_hi_o,
  output logic [HW-1:0] dxr_lo_o,
  output logic          xrdy_o,
  output logic [DW-1:0] buf_word_o,
  output logic [IW-1:0] buf_top_o,
  output logic          buf_full_o
);

  logic pending_q;
  logic copy;

  assign copy = pending_q & ~buf_full_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dxr_hi_o   <= '0;
      dxr_lo_o   <= '0;
      pending_q  <= 1'b0;
      xrdy_o     <= 1'b1;
      buf_word_o <= '0;
      buf_top_o  <= IW'(7);
      buf_full_o <= 1'b0;
    end else begin
      if (wr_hi_i) dxr_hi_o <= wdata_i;
      if (copy) begin
        buf_word_o <= conv_word_i;
        buf_top_o  <= conv_top_i;
      end
      // a new low write wins over a same-cycle copy of the older word
      if (wr_lo_i) begin
        dxr_lo_o  <= wdata_i;
        pending_q <= 1'b1;
        xrdy_o    <= 1'b0;
      end else if (copy) begin
        pending_q <= 1'b0;
        xrdy_o    <= 1'b1;
      end
      if (copy)        buf_full_o <= 1'b1;
      else if (take_i) buf_full_o <= 1'b0;
    end
  end

endmodule

// File: rtl/fsp_tx_shift.sv
module fsp_tx_shift #(
  parameter  int DW = 32,
  localparam int IW = $clog2(DW)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          bit_en_i,
  input  logic          fs_i,
  input  logic [1:0]    delay_i,
  input  logic          uf_clr_i,
  input  logic [DW-1:0] buf_word_i,
  input  logic [IW-1:0] buf_top_i,
  input  logic          buf_full_i,
  output logic          take_o,
  output logic          dx_o,
  output logic          dx_oe_o,
  output logic          uf_o
);
  import fsp_tx_pkg::*;

  tx_state_e     state_q;
  logic [1:0]    dcnt_q;
  logic [IW-1:0] idx_q;
  logic [DW-1:0] sreg_q;
  logic [1:0]    dly_eff;
  logic          free;

  assign dly_eff = (delay_i == 2'b11) ? 2'd2 : delay_i;
  // free also in the slot right after the LSB, for gapless frames
  assign free    = (state_q == ST_IDLE) || ((state_q == ST_SHIFT) && (idx_q == '0));
  assign take_o  = bit_en_i & fs_i & free;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      dcnt_q  <= '0;
      idx_q   <= '0;
      sreg_q  <= '0;
      dx_o    <= 1'b0;
      dx_oe_o <= 1'b0;
    end else if (take_o) begin
      sreg_q <= buf_word_i;
      idx_q  <= buf_top_i;
      if (dly_eff == 2'd0) begin
        dx_o    <= buf_word_i[buf_top_i];
        dx_oe_o <= 1'b1;
        state_q <= ST_SHIFT;
      end else begin
        dcnt_q  <= dly_eff - 2'd1;
        dx_o    <= 1'b0;
        dx_oe_o <= 1'b0;
        state_q <= ST_DELAY;
      end
    end else if (bit_en_i) begin
      unique case (state_q)
        ST_DELAY: begin
          if (dcnt_q == '0) begin
            dx_o    <= sreg_q[idx_q];
            dx_oe_o <= 1'b1;
            state_q <= ST_SHIFT;
          end else begin
            dcnt_q <= dcnt_q - 2'd1;
          end
        end
        ST_SHIFT: begin
          if (idx_q != '0) begin
            idx_q <= idx_q - IW'(1);
            dx_o  <= sreg_q[idx_q - IW'(1)];
          end else begin
            dx_o    <= 1'b0;
            dx_oe_o <= 1'b0;
            state_q <= ST_IDLE;
          end
        end
        default: begin
          dx_o    <= 1'b0;
          dx_oe_o <= 1'b0;
          state_q <= ST_IDLE;
        end
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   uf_o <= 1'b0;
    else if (take_o & ~buf_full_i) uf_o <= 1'b1;
    else if (uf_clr_i)             uf_o <= 1'b0;
  end

endmodule

// File: rtl/fsp_tx.sv
module fsp_tx #(
  parameter  int DW = 32,
  localparam int HW = DW / 2,
  localparam int IW = $clog2(DW)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_lo_i,
  input  logic          wr_hi_i,
  input  logic [HW-1:0] wdata_i,
  input  logic [IW-1:0] wlen_i,
  input  logic [1:0]    cmp_mode_i,
  input  logic [1:0]    delay_i,
  input  logic          bit_en_i,
  input  logic          fs_i,
  input  logic          uf_clr_i,
  output logic          xrdy_o,
  output logic          dx_o,
  output logic          dx_oe_o,
  output logic          uf_o
);

  logic [HW-1:0] dxr_hi, dxr_lo;
  logic [DW-1:0] conv_word, buf_word;
  logic [IW-1:0] conv_top, buf_top;
  logic          buf_full, take;

  fsp_tx_compand #(.DW(DW)) u_compand (
    .cmp_mode_i (cmp_mode_i),
    .wlen_i     (wlen_i),
    .hi_i       (dxr_hi),
    .lo_i       (dxr_lo),
    .word_o     (conv_word),
    .top_o      (conv_top)
  );

  fsp_tx_hold #(.DW(DW)) u_hold (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_lo_i     (wr_lo_i),
    .wr_hi_i     (wr_hi_i),
    .wdata_i     (wdata_i),
    .conv_word_i (conv_word),
    .conv_top_i  (conv_top),
    .take_i      (take),
    .dxr_hi_o    (dxr_hi),
    .dxr_lo_o    (dxr_lo),
    .xrdy_o      (xrdy_o),
    .buf_word_o  (buf_word),
    .buf_top_o   (buf_top),
    .buf_full_o  (buf_full)
  );

  fsp_tx_shift #(.DW(DW)) u_shift (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .bit_en_i   (bit_en_i),
    .fs_i       (fs_i),
    .delay_i    (delay_i),
    .uf_clr_i   (uf_clr_i),
    .buf_word_i (buf_word),
    .buf_top_i  (buf_top),
    .buf_full_i (buf_full),
    .take_o     (take),
    .dx_o       (dx_o),
    .dx_oe_o    (dx_oe_o),
    .uf_o       (uf_o)
  );

endmodule

// File: rtl/fsp_tx_chk.sv
module fsp_tx_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic wr_lo_i,
  input logic bit_en_i,
  input logic fs_i,
  input logic uf_clr_i,
  input logic xrdy_o,
  input logic dx_o,
  input logic dx_oe_o,
  input logic uf_o
);

  // R2
  wr_lo_drops_rdy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_lo_i |=> !xrdy_o);

  // R2
  rdy_rise_no_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(xrdy_o) |-> $past(!wr_lo_i));

  // R4
  serial_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bit_en_i |=> ($stable(dx_o) && $stable(dx_oe_o)));

  // R12
  quiet_line_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dx_oe_o |-> !dx_o);

  // R11
  uf_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (uf_o && !uf_clr_i) |=> uf_o);

  // R11
  uf_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (uf_clr_i && !(fs_i && bit_en_i)) |=> !uf_o);

endmodule

bind fsp_tx fsp_tx_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .wr_lo_i  (wr_lo_i),
  .bit_en_i (bit_en_i),
  .fs_i     (fs_i),
  .uf_clr_i (uf_clr_i),
  .xrdy_o   (xrdy_o),
  .dx_o     (dx_o),
  .dx_oe_o  (dx_oe_o),
  .uf_o     (uf_o)
);

// File: tb/fsp_tx_tb_top.sv
`timescale 1ns/1ps
module fsp_tx_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_lo = 1'b0, wr_hi = 1'b0;
  logic [15:0] wdata = '0;
  logic [4:0]  wlen = 5'd7;
  logic [1:0]  cmp = 2'd0, dly = 2'd0;
  logic        bit_en = 1'b0, fs = 1'b0, uf_clr = 1'b0;
  logic        xrdy, dx, dx_oe, uf;

  int n_chk = 0;
  int n_err = 0;

  always #2.5 clk = ~clk;

  fsp_tx dut_i (
    .clk_i(clk), .rst_ni(rst_n), .wr_lo_i(wr_lo), .wr_hi_i(wr_hi), .wdata_i(wdata),
    .wlen_i(wlen), .cmp_mode_i(cmp), .delay_i(dly), .bit_en_i(bit_en), .fs_i(fs),
    .uf_clr_i(uf_clr), .xrdy_o(xrdy), .dx_o(dx), .dx_oe_o(dx_oe), .uf_o(uf)
  );

  typedef struct packed {
    logic [4:0]  wlen;
    logic [1:0]  cmp;
    logic [1:0]  dly;
    logic [15:0] hi;
    logic [15:0] lo;
    logic [5:0]  exp_len;
    logic [3:0]  req;
  } vec_t;

  localparam vec_t VECS [12] = '{
    '{5'd7,  2'd0, 2'd0, 16'h0000, 16'h00A5, 6'd8,  4'd4},  // R4 8 bits, no delay
    '{5'd15, 2'd1, 2'd1, 16'h0000, 16'hBEEF, 6'd16, 4'd8},  // R8 mode 01 passes through
    '{5'd31, 2'd0, 2'd2, 16'h1234, 16'h5678, 6'd32, 4'd4},  // R4 full 32 bits
    '{5'd23, 2'd0, 2'd3, 16'h00C3, 16'h9ABC, 6'd24, 4'd9},  // R9 code 3 acts as 2
    '{5'd3,  2'd0, 2'd0, 16'h0000, 16'h0F5A, 6'd8,  4'd4},  // R4 short length clamps to 8
    '{5'd31, 2'd2, 2'd1, 16'hFFFF, 16'h0000, 6'd8,  4'd6},  // R6
    '{5'd31, 2'd2, 2'd0, 16'hFFFF, 16'h8000, 6'd8,  4'd6},  // R6 clip
    '{5'd15, 2'd2, 2'd0, 16'h0000, 16'h1234, 6'd8,  4'd6},  // R6
    '{5'd31, 2'd3, 2'd0, 16'hFFFF, 16'h0000, 6'd8,  4'd7},  // R7
    '{5'd31, 2'd3, 2'd2, 16'h0000, 16'hFFFF, 6'd8,  4'd7},  // R7 negative small
    '{5'd7,  2'd3, 2'd1, 16'h0000, 16'h4321, 6'd8,  4'd7},  // R7
    '{5'd7,  2'd3, 2'd0, 16'h0000, 16'h0005, 6'd8,  4'd7}   // R7 first segment
  };

  function automatic int mu_ref(int x);
    int sgn, m, e, mn;
    sgn = (x < 0) ? 1 : 0;
    m = sgn ? -x : x;
    if (m > 32635) m = 32635;
    m = m + 132;
    e = 7;
    while (e > 0 && m < (1 << (e + 7))) e--;
    mn = (m >> (e + 3)) & 15;
    return (~((sgn << 7) | (e << 4) | mn)) & 255;
  endfunction

  function automatic int a_ref(int x);
    int t, m, e, mn;
    bit pos;
    t = x >>> 3;
    pos = (t >= 0);
    m = pos ? t : -t - 1;
    e = 7;
    while (e > 0 && m < (1 << (e + 4))) e--;
    mn = (e < 2) ? ((m >> 1) & 15) : ((m >> e) & 15);
    return ((e << 4) | mn) ^ (pos ? 'hD5 : 'h55);
  endfunction

  function automatic logic [31:0] exp_word(vec_t v);
    int x;
    logic [63:0] w;
    x = int'($signed(v.lo));
    if (v.cmp == 2'b10) return 32'(mu_ref(x));
    if (v.cmp == 2'b11) return 32'(a_ref(x));
    w = {32'd0, v.hi, v.lo};
    return 32'(w & ((64'd1 << v.exp_len) - 64'd1));
  endfunction

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // one bit slot: enable high for one clock, sample after its edge, then two idle clocks
  task automatic tick(input bit f, output logic o, output logic d);
    bit_en = 1'b1;
    fs = f;
    @(negedge clk);
    bit_en = 1'b0;
    fs = 1'b0;
    o = dx_oe;
    d = dx;
    repeat (2) @(negedge clk);
  endtask

  task automatic host_write(input bit hi_en, input logic [15:0] hi, input logic [15:0] lo,
                            output logic r0, output logic r1);
    if (hi_en) begin
      wr_hi = 1'b1; wdata = hi;
      @(negedge clk);
      wr_hi = 1'b0;
    end
    wr_lo = 1'b1; wdata = lo;
    @(negedge clk);
    wr_lo = 1'b0;
    r0 = xrdy;
    @(negedge clk);
    r1 = xrdy;
  endtask

  // send one frame; checks the enable window (R9/R12) and the data (tag)
  task automatic run_frame(input logic [31:0] w, input int len, input int d, input string tag);
    logic o, b;
    logic [31:0] got;
    bit win_ok;
    got = '0;
    win_ok = 1'b1;
    for (int s = 0; s <= d + len; s++) begin
      tick(s == 0, o, b);
      if (s < d || s == d + len) begin
        if (o !== 1'b0 || b !== 1'b0) win_ok = 1'b0;  // R12
      end else begin
        if (o !== 1'b1) win_ok = 1'b0;
        got = {got[30:0], b};
      end
    end
    check(win_ok, "R9 window", 64'(win_ok), 64'd1);
    check(got === w, tag, 64'(got), 64'(w));
  endtask

  initial begin
    repeat (2000000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    logic r0, r1, o, b;
    logic [31:0] got;
    bit win_ok;
    vec_t v;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    check(xrdy === 1'b1, "R1 xrdy", 64'(xrdy), 64'd1);
    check(dx_oe === 1'b0, "R1 oe", 64'(dx_oe), 64'd0);
    check(dx === 1'b0, "R1 dx", 64'(dx), 64'd0);
    check(uf === 1'b0, "R1 uf", 64'(uf), 64'd0);

    for (int i = 0; i < 12; i++) begin
      v = VECS[i];
      wlen = v.wlen; cmp = v.cmp; dly = v.dly;
      host_write(1'b1, v.hi, v.lo, r0, r1);
      check(r0 === 1'b0, "R2 ready low", 64'(r0), 64'd0);
      check(r1 === 1'b1, "R2 ready back", 64'(r1), 64'd1);
      run_frame(exp_word(v), int'(v.exp_len), (v.dly == 2'd3) ? 2 : int'(v.dly),
                $sformatf("R%0d vec %0d", v.req, i));
    end
    check(uf === 1'b0, "R11 no underflow yet", 64'(uf), 64'd0);

    // R5 stale high half
    wlen = 5'd31; cmp = 2'd0; dly = 2'd0;
    host_write(1'b1, 16'hAAAA, 16'h0001, r0, r1);
    run_frame(32'hAAAA0001, 32, 0, "R5 first");
    host_write(1'b0, 16'h0000, 16'h0002, r0, r1);
    run_frame(32'hAAAA0002, 32, 0, "R5 stale high");

    // R3 second word waits while buffer full
    wlen = 5'd7;
    host_write(1'b0, 16'h0, 16'h0011, r0, r1);
    host_write(1'b0, 16'h0, 16'h0022, r0, r1);
    repeat (3) @(negedge clk);
    check(xrdy === 1'b0, "R3 held low", 64'(xrdy), 64'd0);
    run_frame(32'h11, 8, 0, "R3 first word");
    check(xrdy === 1'b1, "R3 ready after take", 64'(xrdy), 64'd1);
    run_frame(32'h22, 8, 0, "R3 second word");

    // R10 ignored mid-word sync, then gapless next word
    host_write(1'b0, 16'h0, 16'h003C, r0, r1);
    host_write(1'b0, 16'h0, 16'h00C3, r0, r1);
    got = '0;
    win_ok = 1'b1;
    for (int s = 0; s < 17; s++) begin
      tick(s == 0 || s == 3 || s == 8, o, b);
      if (s < 16) begin
        if (o !== 1'b1) win_ok = 1'b0;
        got = {got[30:0], b};
      end else if (o !== 1'b0) win_ok = 1'b0;
    end
    check(win_ok, "R10 continuous enable", 64'(win_ok), 64'd1);
    check(got[15:0] === 16'h3CC3, "R10 two words", 64'(got[15:0]), 64'h3CC3);
    check(uf === 1'b0, "R10 no underflow", 64'(uf), 64'd0);

    // R11 underflow resends last word
    run_frame(32'hC3, 8, 0, "R11 resend");
    check(uf === 1'b1, "R11 set", 64'(uf), 64'd1);
    repeat (4) @(negedge clk);
    check(uf === 1'b1, "R11 sticky", 64'(uf), 64'd1);
    uf_clr = 1'b1;
    @(negedge clk);
    uf_clr = 1'b0;
    check(uf === 1'b0, "R11 cleared", 64'(uf), 64'd0);

    // R12 idle line
    check(dx_oe === 1'b0 && dx === 1'b0, "R12 idle", 64'({dx_oe, dx}), 64'd0);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule